// File: doc/BRIEF.md
# Descriptor-Driven NVM Transfer Sequencer

This block moves the contents of a scattered register space into a byte-wide nonvolatile memory and back again. A 23-byte descriptor table inside the block says which register ranges to move. Each entry is either a segment, which gives a start address and a byte count, or a one-byte opcode. An opcode can request a buffer-to-active commit of the register bank or end the list. The sequencer walks the table from entry 0. Memory bytes are packed one after another from memory address 0, so the scattered ranges occupy a contiguous image in the memory.

A store pass reads registers through the register bank read port and writes them to the memory. After the end marker it appends an 8-bit checksum. A load pass reads the memory back, writes the register bank, issues a commit wherever the table asks for one, and compares the checksum it recomputes with the stored one. A busy flag covers the whole pass. An error flag reports a checksum mismatch or a malformed table. The register bank and the memory both answer a read in the cycle after the request.

Top module: `segxfer_top`

## Requirements
- R1: After reset, busy and err are 0, every strobe output (reg_rd_en, reg_wr_en, reg_commit, nvm_en) is 0, and the table holds its default contents.
- R2: A segment descriptor is three bytes: {0, count-1[6:0]}, then start address [15:8], then start address [7:0]. On a store, a segment's registers go in ascending address order to consecutive memory addresses. The first data byte goes to address 0, and the next segment continues where the previous one stopped.
- R3: A load copies the memory image back, in the same order, to the registers named by the table. Registers outside the listed segments are not written.
- R4: Opcode 0x80 (commit) makes a load pulse reg_commit for one cycle, after all register writes of earlier segments and before any of later ones. During a store it causes no pulse.
- R5: Opcode 0xFF (end) stops the walk. A store then writes the checksum, (0x5A + sum of all data bytes) mod 256, at the memory address after the last data byte, and nothing after it.
- R6: A load reads the checksum byte that follows the image. err reads 1 after completion if that byte differs from the recomputed value, and 0 if it matches.
- R7: cmd_start while busy is ignored: the pass in progress continues in its original direction and is not restarted.
- R8: An accepted start clears err, which reads 0 in the cycle after the start.
- R9: If the walk reaches entry 23 without an end marker, meets a segment whose three bytes do not fit in the table, or meets a byte with bit 7 set other than 0x80 or 0xFF, the pass stops with err=1. No checksum is written or checked.
- R10: The default table is a segment of 128 bytes at 0x0000, then a segment of 128 bytes at 0x0080, then commit, then end, so a pass covers registers 0x00 to 0xFF.
- R11: busy is 1 from the cycle after an accepted start until the pass completes, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse; accepted only while idle |
| cmd_store | input | 1 | Direction with cmd_start: 1 store to memory, 0 load from memory |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | 5 | Descriptor table entry index |
| tbl_wdata | input | 8 | Descriptor table write data |
| busy | output | 1 | Pass in progress |
| err | output | 1 | Checksum mismatch or malformed table in the last pass |
| reg_rd_en | output | 1 | Register bank read request |
| reg_wr_en | output | 1 | Register bank write strobe |
| reg_addr | output | 16 | Register bank address |
| reg_wdata | output | 8 | Register bank write data |
| reg_rdata | input | 8 | Register bank read data, one cycle after the request |
| reg_commit | output | 1 | One-cycle buffer-to-active commit request |
| nvm_en | output | 1 | Memory access strobe |
| nvm_we | output | 1 | Memory write enable (with nvm_en) |
| nvm_addr | output | 10 | Memory byte address |
| nvm_wdata | output | 8 | Memory write data |
| nvm_rdata | input | 8 | Memory read data, one cycle after the request |

## Verification
Some properties can be judged on every cycle, and the assertions cover those. At most one of the register read, register write and memory strobes is active at a time. A store never writes registers or pulses a commit, and a load never writes the memory. Strobes stay quiet and err holds its value while the block is idle. busy rises only after an accepted start, and err clears after one. Byte ordering, packing across segments, the checksum value, the position of a commit relative to the segment writes, and the outcome of each malformed table depend on data, so only the directed scenarios can show them. Each scenario compares the register and memory models against values the bench computes itself.

// File: rtl/segxfer_pkg.sv
package segxfer_pkg;

    localparam int unsigned REG_AW = 16;

    localparam logic [7:0] OP_COMMIT = 8'h80;
    localparam logic [7:0] OP_END    = 8'hFF;

    typedef enum logic [1:0] {
        K_SEG,
        K_COMMIT,
        K_END,
        K_BAD
    } desc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_MOVE_A,
        ST_MOVE_B,
        ST_SUM_WR,
        ST_SUM_RD,
        ST_SUM_CMP
    } seq_state_e;

    // Power-up table: two 128-byte segments spanning 0x00..0xFF, commit, end.
    function automatic logic [7:0] dflt_byte(int unsigned i);
        logic [7:0] b;
        case (i)
            0:       b = 8'h7F;
            1:       b = 8'h00;
            2:       b = 8'h00;
            3:       b = 8'h7F;
            4:       b = 8'h00;
            5:       b = 8'h80;
            6:       b = OP_COMMIT;
            default: b = OP_END;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/segxfer_table.sv
module segxfer_table #(
    parameter int unsigned TBL_BYTES = 23,
    parameter int unsigned TBL_IW    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [TBL_IW-1:0]           idx,
    input  logic [7:0]                  wdata,
    output logic [TBL_BYTES-1:0][7:0]   entries
);
    import segxfer_pkg::*;

    logic [TBL_BYTES-1:0][7:0] ent_d, ent_q;

    generate
        for (genvar g = 0; g < TBL_BYTES; g++) begin : g_entry
            always_comb begin
                ent_d[g] = ent_q[g];
                if (we && (idx == TBL_IW'(g))) begin
                    ent_d[g] = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q[g] <= dflt_byte(g);
                end else begin
                    ent_q[g] <= ent_d[g];
                end
            end
        end
    endgenerate

    assign entries = ent_q;

endmodule

// File: rtl/segxfer_decode.sv
module segxfer_decode #(
    parameter int unsigned TBL_BYTES = 23,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [TBL_BYTES-1:0][7:0]       entries,
    input  logic [IDX_W-1:0]                idx,
    output segxfer_pkg::desc_kind_e         kind,
    output logic [6:0]                      cnt_m1,
    output logic [segxfer_pkg::REG_AW-1:0]  start_addr
);
    import segxfer_pkg::*;

    logic [7:0] b0, b1, b2;
    int unsigned pos;

    always_comb begin
        b0  = 8'h00;
        b1  = 8'h00;
        b2  = 8'h00;
        pos = 32'(idx);
        for (int i = 0; i < int'(TBL_BYTES); i++) begin
            if (pos == i)     b0 = entries[i];
            if (pos + 1 == i) b1 = entries[i];
            if (pos + 2 == i) b2 = entries[i];
        end
    end

    always_comb begin
        if (pos >= TBL_BYTES) begin
            kind = K_BAD;
        end else if (!b0[7]) begin
            kind = (pos + 2 >= TBL_BYTES) ? K_BAD : K_SEG;
        end else if (b0 == OP_COMMIT) begin
            kind = K_COMMIT;
        end else if (b0 == OP_END) begin
            kind = K_END;
        end else begin
            kind = K_BAD;
        end
    end

    assign cnt_m1     = b0[6:0];
    assign start_addr = {b1, b2};

endmodule

// File: rtl/segxfer_ctrl.sv
module segxfer_ctrl #(
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned NVM_AW    = 10,
    parameter logic [7:0]  CSUM_SEED = 8'h5A
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_start,
    input  logic                            cmd_store,
    input  segxfer_pkg::desc_kind_e         kind,
    input  logic [6:0]                      dec_cnt_m1,
    input  logic [segxfer_pkg::REG_AW-1:0]  dec_addr,
    output logic [IDX_W-1:0]                idx,
    output logic                            busy,
    output logic                            err,
    output logic                            reg_rd_en,
    output logic                            reg_wr_en,
    output logic [segxfer_pkg::REG_AW-1:0]  reg_addr,
    output logic [7:0]                      reg_wdata,
    input  logic [7:0]                      reg_rdata,
    output logic                            reg_commit,
    output logic                            nvm_en,
    output logic                            nvm_we,
    output logic [NVM_AW-1:0]               nvm_addr,
    output logic [7:0]                      nvm_wdata,
    input  logic [7:0]                      nvm_rdata
);
    import segxfer_pkg::*;

    typedef struct packed {
        seq_state_e          st;
        logic                store;
        logic [IDX_W-1:0]    idx;
        logic [6:0]          cnt;
        logic [REG_AW-1:0]   addr;
        logic [NVM_AW-1:0]   ptr;
        logic [7:0]          csum;
        logic                err;
        logic                commit;
    } seq_t;

    seq_t q, d;
    logic [7:0] moved;

    assign moved = q.store ? reg_rdata : nvm_rdata;

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    d.st    = ST_DESC;
                    d.store = cmd_store;
                    d.idx   = '0;
                    d.ptr   = '0;
                    d.csum  = CSUM_SEED;
                    d.err   = 1'b0;
                end
            end
            ST_DESC: begin
                case (kind)
                    K_SEG: begin
                        d.cnt  = dec_cnt_m1;
                        d.addr = dec_addr;
                        d.idx  = q.idx + IDX_W'(3);
                        d.st   = ST_MOVE_A;
                    end
                    K_COMMIT: begin
                        d.commit = !q.store;
                        d.idx    = q.idx + IDX_W'(1);
                    end
                    K_END: begin
                        d.st = q.store ? ST_SUM_WR : ST_SUM_RD;
                    end
                    default: begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end
                endcase
            end
            ST_MOVE_A: begin
                d.st = ST_MOVE_B;
            end
            ST_MOVE_B: begin
                d.csum = q.csum + moved;
                d.ptr  = q.ptr + NVM_AW'(1);
                if (q.cnt == 7'd0) begin
                    d.st = ST_DESC;
                end else begin
                    d.cnt  = q.cnt - 7'd1;
                    d.addr = q.addr + REG_AW'(1);
                    d.st   = ST_MOVE_A;
                end
            end
            ST_SUM_WR: begin
                d.st = ST_IDLE;
            end
            ST_SUM_RD: begin
                d.st = ST_SUM_CMP;
            end
            ST_SUM_CMP: begin
                d.err = (nvm_rdata != q.csum);
                d.st  = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, store: 1'b0, idx: '0, cnt: '0, addr: '0,
                   ptr: '0, csum: '0, err: 1'b0, commit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign idx        = q.idx;
    assign busy       = (q.st != ST_IDLE);
    assign err        = q.err;
    assign reg_commit = q.commit;

    assign reg_rd_en  = (q.st == ST_MOVE_A) && q.store;
    assign reg_wr_en  = (q.st == ST_MOVE_B) && !q.store;
    assign reg_addr   = q.addr;
    assign reg_wdata  = nvm_rdata;

    assign nvm_en     = ((q.st == ST_MOVE_A) && !q.store) ||
                        ((q.st == ST_MOVE_B) && q.store)  ||
                        (q.st == ST_SUM_WR) || (q.st == ST_SUM_RD);
    assign nvm_we     = ((q.st == ST_MOVE_B) && q.store) || (q.st == ST_SUM_WR);
    assign nvm_addr   = q.ptr;
    assign nvm_wdata  = (q.st == ST_SUM_WR) ? q.csum : reg_rdata;

endmodule

// File: rtl/segxfer_top.sv
module segxfer_top #(
    parameter int unsigned TBL_BYTES = 23,
    parameter int unsigned NVM_AW    = 10,
    parameter logic [7:0]  CSUM_SEED = 8'h5A,
    localparam int unsigned TBL_IW   = $clog2(TBL_BYTES),
    localparam int unsigned IDX_W    = $clog2(TBL_BYTES + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic               cmd_store,
    input  logic               tbl_we,
    input  logic [TBL_IW-1:0]  tbl_idx,
    input  logic [7:0]         tbl_wdata,
    output logic               busy,
    output logic               err,
    output logic               reg_rd_en,
    output logic               reg_wr_en,
    output logic [15:0]        reg_addr,
    output logic [7:0]         reg_wdata,
    input  logic [7:0]         reg_rdata,
    output logic               reg_commit,
    output logic               nvm_en,
    output logic               nvm_we,
    output logic [NVM_AW-1:0]  nvm_addr,
    output logic [7:0]         nvm_wdata,
    input  logic [7:0]         nvm_rdata
);
    import segxfer_pkg::*;

    logic [TBL_BYTES-1:0][7:0] entries;
    logic [IDX_W-1:0]          walk_idx;
    desc_kind_e                kind;
    logic [6:0]                dec_cnt_m1;
    logic [REG_AW-1:0]         dec_addr;

    segxfer_table #(.TBL_BYTES(TBL_BYTES), .TBL_IW(TBL_IW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .idx     (tbl_idx),
        .wdata   (tbl_wdata),
        .entries (entries)
    );

    segxfer_decode #(.TBL_BYTES(TBL_BYTES), .IDX_W(IDX_W)) u_decode (
        .entries    (entries),
        .idx        (walk_idx),
        .kind       (kind),
        .cnt_m1     (dec_cnt_m1),
        .start_addr (dec_addr)
    );

    segxfer_ctrl #(.IDX_W(IDX_W), .NVM_AW(NVM_AW), .CSUM_SEED(CSUM_SEED)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_store  (cmd_store),
        .kind       (kind),
        .dec_cnt_m1 (dec_cnt_m1),
        .dec_addr   (dec_addr),
        .idx        (walk_idx),
        .busy       (busy),
        .err        (err),
        .reg_rd_en  (reg_rd_en),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_commit (reg_commit),
        .nvm_en     (nvm_en),
        .nvm_we     (nvm_we),
        .nvm_addr   (nvm_addr),
        .nvm_wdata  (nvm_wdata),
        .nvm_rdata  (nvm_rdata)
    );

endmodule

// File: rtl/segxfer_chk.sv
module segxfer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic cmd_store,
    input logic busy,
    input logic err,
    input logic reg_rd_en,
    input logic reg_wr_en,
    input logic reg_commit,
    input logic nvm_en,
    input logic nvm_we
);
    // Direction of the pass in progress, tracked from the ports only.
    logic dir_store_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 dir_store_q <= 1'b0;
        else if (cmd_start && !busy) dir_store_q <= cmd_store;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(reg_rd_en || reg_wr_en || nvm_en || reg_commit));

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd_en, reg_wr_en, nvm_en}));

    a_r3_load_no_nvm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dir_store_q) |-> !(nvm_en && nvm_we));

    a_r4_store_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_store_q) |-> !(reg_commit || reg_wr_en));

    a_r8_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> !err);

    a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> busy);

    a_r7_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));

    a_r6_err_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_start) |=> $stable(err));

endmodule

bind segxfer_top segxfer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_store  (cmd_store),
    .busy       (busy),
    .err        (err),
    .reg_rd_en  (reg_rd_en),
    .reg_wr_en  (reg_wr_en),
    .reg_commit (reg_commit),
    .nvm_en     (nvm_en),
    .nvm_we     (nvm_we)
);

// File: tb/segxfer_top_test.sv
`timescale 1ns/1ps
module segxfer_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_store = 1'b0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_idx = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        busy, err;
    logic        reg_rd_en, reg_wr_en, reg_commit;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata = '0;
    logic        nvm_en, nvm_we;
    logic [9:0]  nvm_addr;
    logic [7:0]  nvm_wdata;
    logic [7:0]  nvm_rdata = '0;

    always #2 clk = ~clk;

    segxfer_top uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_store(cmd_store),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .busy(busy), .err(err),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_commit(reg_commit),
        .nvm_en(nvm_en), .nvm_we(nvm_we), .nvm_addr(nvm_addr),
        .nvm_wdata(nvm_wdata), .nvm_rdata(nvm_rdata)
    );

    // Register bank and memory models, one-cycle read latency.
    logic [7:0] regs [256];
    logic [7:0] nvm  [1024];
    int wr_cnt = 0, commit_cnt = 0, nvm_wr_cnt = 0, wr_at_commit = -1;

    always @(posedge clk) begin
        if (reg_rd_en) reg_rdata <= regs[reg_addr[7:0]];
        if (nvm_en) begin
            if (nvm_we) begin
                nvm[nvm_addr] = nvm_wdata;
                nvm_wr_cnt = nvm_wr_cnt + 1;
            end else begin
                nvm_rdata <= nvm[nvm_addr];
            end
        end
        if (reg_wr_en) begin
            regs[reg_addr[7:0]] = reg_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (reg_commit) begin
            commit_cnt = commit_cnt + 1;
            wr_at_commit = wr_cnt;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    function automatic logic [7:0] pat(int i, int salt);
        return 8'((i * 7 + 3 + salt * 29) & 8'hFF);
    endfunction

    task automatic clear_counts();
        wr_cnt = 0; commit_cnt = 0; nvm_wr_cnt = 0; wr_at_commit = -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tbl_put(input int i, input logic [7:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 5'(i); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Start a pass, check the first cycle, wait for completion.
    task automatic run(input logic store);
        @(negedge clk);
        cmd_start = 1'b1; cmd_store = store;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R11", "busy after start", 32'(busy), 32'd1);
        chk("R8", "err cleared at start", 32'(err), 32'd0);
        for (int n = 0; n < 4000 && busy; n++) @(negedge clk);
        chk("R11", "busy released", 32'(busy), 32'd0);
    endtask

    // Table used by the custom scenarios: 3 @0x10, commit, 2 @0x40, end.
    task automatic load_custom_table();
        tbl_put(0, 8'h02); tbl_put(1, 8'h00); tbl_put(2, 8'h10);
        tbl_put(3, 8'h80);
        tbl_put(4, 8'h01); tbl_put(5, 8'h00); tbl_put(6, 8'h40);
        tbl_put(7, 8'hFF);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "err", 32'(err), 32'd0);
        chk("R1", "strobes", 32'({reg_rd_en, reg_wr_en, reg_commit, nvm_en}), 32'd0);
    endtask

    task automatic t_default_store();
        logic [7:0] cs;
        int bad;
        cs = 8'h5A; bad = 0;
        for (int i = 0; i < 256; i++) begin regs[i] = pat(i, 0); cs = cs + pat(i, 0); end
        for (int i = 0; i < 1024; i++) nvm[i] = 8'hEE;
        clear_counts();
        run(1'b1);
        for (int i = 0; i < 256; i++) if (nvm[i] !== pat(i, 0)) bad++;
        chk("R10", "default image bytes wrong", 32'(bad), 32'd0);
        chk("R5", "checksum byte", 32'(nvm[256]), 32'(cs));
        chk("R5", "byte after checksum", 32'(nvm[257]), 32'hEE);
        chk("R4", "commits in store", 32'(commit_cnt), 32'd0);
        chk("R5", "err after store", 32'(err), 32'd0);
    endtask

    task automatic t_default_load();
        int bad;
        bad = 0;
        for (int i = 0; i < 256; i++) regs[i] = 8'h00;
        clear_counts();
        run(1'b0);
        for (int i = 0; i < 256; i++) if (regs[i] !== pat(i, 0)) bad++;
        chk("R3", "default load bytes wrong", 32'(bad), 32'd0);
        chk("R10", "commits in default load", 32'(commit_cnt), 32'd1);
        chk("R4", "writes before commit", 32'(wr_at_commit), 32'd256);
        chk("R6", "err after good load", 32'(err), 32'd0);
    endtask

    task automatic t_custom_store();
        logic [7:0] cs;
        for (int i = 0; i < 256; i++) regs[i] = pat(i, 1);
        for (int i = 0; i < 1024; i++) nvm[i] = 8'hEE;
        cs = 8'h5A + pat(16, 1) + pat(17, 1) + pat(18, 1) + pat(64, 1) + pat(65, 1);
        clear_counts();
        run(1'b1);
        chk("R2", "nvm[0]", 32'(nvm[0]), 32'(pat(16, 1)));
        chk("R2", "nvm[2]", 32'(nvm[2]), 32'(pat(18, 1)));
        chk("R2", "nvm[3] second segment", 32'(nvm[3]), 32'(pat(64, 1)));
        chk("R2", "nvm[4]", 32'(nvm[4]), 32'(pat(65, 1)));
        chk("R5", "custom checksum", 32'(nvm[5]), 32'(cs));
        chk("R5", "nvm[6] untouched", 32'(nvm[6]), 32'hEE);
        chk("R4", "no commit in store", 32'(commit_cnt), 32'd0);
    endtask

    task automatic t_custom_load();
        regs[16] = 0; regs[17] = 0; regs[18] = 0; regs[64] = 0; regs[65] = 0;
        regs[19] = 8'h33; regs[63] = 8'h44;
        clear_counts();
        run(1'b0);
        chk("R3", "reg 0x10", 32'(regs[16]), 32'(pat(16, 1)));
        chk("R3", "reg 0x12", 32'(regs[18]), 32'(pat(18, 1)));
        chk("R3", "reg 0x41", 32'(regs[65]), 32'(pat(65, 1)));
        chk("R3", "reg 0x13 untouched", 32'(regs[19]), 32'h33);
        chk("R3", "reg 0x3F untouched", 32'(regs[63]), 32'h44);
        chk("R3", "write count", 32'(wr_cnt), 32'd5);
        chk("R4", "commit count", 32'(commit_cnt), 32'd1);
        chk("R4", "writes before commit", 32'(wr_at_commit), 32'd3);
        chk("R6", "err on match", 32'(err), 32'd0);
    endtask

    task automatic t_mismatch();
        nvm[5] = nvm[5] ^ 8'h01;
        run(1'b0);
        chk("R6", "err on mismatch", 32'(err), 32'd1);
        run(1'b0);
        chk("R6", "err on repeated mismatch", 32'(err), 32'd1);
        nvm[5] = nvm[5] ^ 8'h01;
        run(1'b0);
        chk("R8", "err cleared by next good pass", 32'(err), 32'd0);
    endtask

    task automatic t_start_busy();
        for (int i = 0; i < 1024; i++) nvm[i] = 8'hEE;
        clear_counts();
        @(negedge clk);
        cmd_start = 1'b1; cmd_store = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        cmd_start = 1'b1; cmd_store = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R7", "still busy", 32'(busy), 32'd1);
        for (int n = 0; n < 4000 && busy; n++) @(negedge clk);
        chk("R7", "no register writes", 32'(wr_cnt), 32'd0);
        chk("R7", "store written count", 32'(nvm_wr_cnt), 32'd6);
        chk("R7", "nvm[3]", 32'(nvm[3]), 32'(pat(64, 1)));
        @(negedge clk);
        chk("R7", "idle after", 32'(busy), 32'd0);
    endtask

    task automatic t_overrun();
        do_reset();
        for (int i = 0; i < 23; i++) tbl_put(i, 8'h80);
        clear_counts();
        run(1'b0);
        chk("R9", "err no end marker", 32'(err), 32'd1);
        chk("R9", "commits before overrun", 32'(commit_cnt), 32'd23);
        do_reset();
        for (int i = 0; i < 23; i++) tbl_put(i, 8'h00);
        clear_counts();
        run(1'b1);
        chk("R9", "err truncated segment", 32'(err), 32'd1);
        chk("R9", "bytes stored, no checksum", 32'(nvm_wr_cnt), 32'd7);
        do_reset();
        tbl_put(0, 8'h90);
        clear_counts();
        run(1'b1);
        chk("R9", "err unknown opcode", 32'(err), 32'd1);
        chk("R9", "no writes on unknown opcode", 32'(nvm_wr_cnt), 32'd0);
    endtask

    initial begin
        t_reset();
        t_default_store();
        t_default_load();
        load_custom_table();
        t_custom_store();
        t_custom_load();
        t_mismatch();
        t_start_busy();
        t_overrun();
        t_reset();
        summary();
        $finish;
    end

endmodule